// File: doc/BRIEF.md
# Bit-Sliced Integer Arithmetic Logic Unit

This block is a purely combinational integer ALU of parameterisable width (32 bits by default). It is assembled from identical one-bit slices. Each slice contains an AND gate, an OR gate, a full adder, a selectable inverter on each operand, and a four-way result selector. A ripple chain links the slices through their carries. The most-significant slice is a variant of the others: beside the carry chain it also forms the signed-overflow flag and the less-than decision. That decision is routed back to the result selector of bit 0.

A 4-bit operation code drives the slices directly. Bit 3 inverts operand A. Bit 2 inverts operand B and also serves as the carry into bit 0. Bits 1:0 choose which value each slice returns. Subtraction, NOR and the signed comparison therefore need no extra datapath; they are just particular settings of these control bits. A zero-detect flag and an unsigned carry-out flag accompany the result.

Top module: `bitslice_alu`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of A and B.
- R2: Code 4'b0001 returns the bitwise OR of A and B.
- R3: Code 4'b1100 returns the bitwise NOR of A and B. It is formed as (~A) AND (~B): the top code bit inverts A, bit 2 inverts B, and bits 1:0 = 00 select the AND path.
- R4: Code 4'b0010 returns A + B modulo 2^WIDTH. The carry-out flag equals the carry leaving the top bit.
- R5: Code 4'b0110 returns A - B, computed as A + ~B + 1. The carry-out flag then equals 1 exactly when A >= B as unsigned numbers.
- R6: For add and subtract, the overflow flag is 1 exactly when the signed result does not fit in WIDTH bits. This equals the carry into the top bit XOR the carry out of it.
- R7: Code 4'b0111 returns 1 when A < B as signed numbers and 0 otherwise. All bits above bit 0 are 0. The answer stays correct when A - B overflows, because the decision is the difference's sign bit XOR the overflow flag.
- R8: The zero flag is 1 exactly when every result bit is 0, for every operation.
- R9: When code bits 1:0 select a logical path (00 or 01), the overflow and carry-out flags are 0.
- R10: For set-on-less-than, the overflow and carry-out flags report the internal subtraction A - B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code: [3] invert A, [2] invert B and carry-in, [1:0] result select |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Operation result |
| ovf_o | output | 1 | Signed overflow of add, subtract or compare |
| cout_o | output | 1 | Carry out of the top slice for arithmetic codes |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block holds no state, so an internal fault shows up on the ports in the same evaluation as the inputs that expose it. A broken carry link in the chain appears only when a carry actually has to cross that bit. For this reason the stimulus mixes random operands with long carry runs such as all-ones plus one and the most negative minus one. A wrong sign-unit equation changes the comparison result only when the subtraction overflows, so the directed cases pair the most negative and most positive operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } op_e;

    typedef struct packed {
        logic inv_a;
        logic inv_b;
        sel_e sel;
        logic arith;
    } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output ctrl_t           ctrl_o
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.inv_a = op_i[3];
        ctrl_d.inv_b = op_i[2];
        ctrl_d.sel   = sel_e'(op_i[1:0]);
        ctrl_d.arith = op_i[1];
    end

    assign ctrl_o = ctrl_d;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic inv_a_i,
    input  logic inv_b_i,
    input  logic cin_i,
    input  logic less_i,
    input  sel_e sel_i,
    output logic res_o,
    output logic cout_o
);
    typedef struct packed {
        logic a_eff;
        logic b_eff;
        logic sum;
        logic cout;
        logic res;
    } slice_t;

    slice_t s_d;

    always_comb begin
        s_d.a_eff = a_i ^ inv_a_i;
        s_d.b_eff = b_i ^ inv_b_i;
        s_d.sum   = s_d.a_eff ^ s_d.b_eff ^ cin_i;
        s_d.cout  = (s_d.a_eff & s_d.b_eff) | (s_d.a_eff & cin_i) | (s_d.b_eff & cin_i);
        unique case (sel_i)
            SEL_AND:  s_d.res = s_d.a_eff & s_d.b_eff;
            SEL_OR:   s_d.res = s_d.a_eff | s_d.b_eff;
            SEL_SUM:  s_d.res = s_d.sum;
            default:  s_d.res = less_i;
        endcase
    end

    assign res_o  = s_d.res;
    assign cout_o = s_d.cout;
endmodule

// File: rtl/alu_sign_unit.sv
module alu_sign_unit (
    input  logic a_i,
    input  logic b_i,
    input  logic inv_a_i,
    input  logic inv_b_i,
    input  logic cin_i,
    input  logic cout_i,
    output logic ovf_o,
    output logic set_o
);
    typedef struct packed {
        logic sign;
        logic ovf;
        logic set;
    } sign_t;

    sign_t g_d;

    always_comb begin
        g_d.sign = (a_i ^ inv_a_i) ^ (b_i ^ inv_b_i) ^ cin_i;
        g_d.ovf  = cin_i ^ cout_i;
        g_d.set  = g_d.sign ^ g_d.ovf;
    end

    assign ovf_o = g_d.ovf;
    assign set_o = g_d.set;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    output logic             zero_o
);
    assign zero_o = ~(|val_i);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             ovf_o,
    output logic             cout_o,
    output logic             zero_o
);
    localparam int MSB = WIDTH - 1;

    ctrl_t            ctrl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] res_w;
    logic             set_w;
    logic             ovf_raw;
    logic             zero_w;

    alu_decode u_dec (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    assign carry[0] = ctrl.inv_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            assign less_in = set_w;
        end else begin : g_upper
            assign less_in = 1'b0;
        end
        alu_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (ctrl.inv_a),
            .inv_b_i (ctrl.inv_b),
            .cin_i   (carry[i]),
            .less_i  (less_in),
            .sel_i   (ctrl.sel),
            .res_o   (res_w[i]),
            .cout_o  (carry[i+1])
        );
    end

    alu_sign_unit u_sign (
        .a_i     (a_i[MSB]),
        .b_i     (b_i[MSB]),
        .inv_a_i (ctrl.inv_a),
        .inv_b_i (ctrl.inv_b),
        .cin_i   (carry[MSB]),
        .cout_i  (carry[WIDTH]),
        .ovf_o   (ovf_raw),
        .set_o   (set_w)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .val_i  (res_w),
        .zero_o (zero_w)
    );

    assign result_o = res_w;
    assign ovf_o    = ctrl.arith & ovf_raw;
    assign cout_o   = ctrl.arith & carry[WIDTH];
    assign zero_o   = zero_w;

    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    assign ref_add = {1'b0, a_i} + {1'b0, b_i};
    assign ref_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};

    always_comb begin
        if (!$isunknown({op_i, a_i, b_i})) begin
            if (op_i == OP_ADD) begin
                a_r4_add_sum: assert ({cout_o, result_o} == ref_add)
                    else $error("add mismatch");
            end
            if (op_i == OP_SUB) begin
                a_r5_sub_diff: assert ({cout_o, result_o} == ref_sub)
                    else $error("sub mismatch");
            end
            if (op_i == OP_SLT) begin
                a_r7_slt_value: assert (result_o == WIDTH'($signed(a_i) < $signed(b_i)))
                    else $error("slt mismatch");
            end
            if (op_i[1] == 1'b0) begin
                a_r9_logic_flags: assert (!ovf_o && !cout_o)
                    else $error("flags on logical op");
            end
            if (op_i == OP_ADD) begin
                a_r6_add_ovf: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("add overflow mismatch");
            end
            a_r8_zero_flag: assert (zero_o == (result_o == '0))
                else $error("zero flag mismatch");
        end
    end
endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [3:0]   op;
    logic [W-1:0] a, b;
    logic [W-1:0] result;
    logic         ovf, cout, zero;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) dut (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .result_o (result),
        .ovf_o    (ovf),
        .cout_o   (cout),
        .zero_o   (zero)
    );

    typedef struct packed {
        logic [W-1:0] r;
        logic         v;
        logic         c;
        logic         z;
    } exp_t;

    function automatic exp_t model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        exp_t e;
        logic [W:0] s;
        e = '0;
        case (o)
            4'b0000: e.r = x & y;
            4'b0001: e.r = x | y;
            4'b1100: e.r = ~(x | y);
            4'b0010: begin
                s = {1'b0, x} + {1'b0, y};
                e.r = s[W-1:0]; e.c = s[W];
                e.v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
            end
            default: begin
                s = {1'b0, x} - {1'b0, y};
                e.c = (x >= y);
                e.v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
                if (o == 4'b0110) e.r = s[W-1:0];
                else e.r = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            end
        endcase
        e.z = (e.r == '0);
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b1100: return "R3";
            4'b0010: return "R4";
            4'b0110: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        exp_t e;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        e = model(o, x, y);
        chk(tag_of(o), {1'b0, result}, {1'b0, e.r});
        chk("R8", {{W{1'b0}}, zero}, {{W{1'b0}}, e.z});
        if (o[1] == 1'b0) begin
            chk("R9", {{(W-1){1'b0}}, ovf, cout}, {(W+1){1'b0}});
        end else if (o == 4'b0111) begin
            chk("R10", {{(W-1){1'b0}}, ovf, cout}, {{(W-1){1'b0}}, e.v, e.c});
        end else begin
            chk("R6", {{W{1'b0}}, ovf}, {{W{1'b0}}, e.v});
            chk(o == 4'b0010 ? "R4" : "R5", {{W{1'b0}}, cout}, {{W{1'b0}}, e.c});
        end
    endtask

    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    initial begin
        logic [3:0] ops [6];
        op = 4'b0000; a = '0; b = '0;
        ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
        ops[3] = 4'b0110; ops[4] = 4'b0111; ops[5] = 4'b1100;
        void'($urandom(32'd1234));
        // reset-like idle state: AND of zeros gives zero result and flags
        run(4'b0000, '0, '0);
        for (int k = 0; k < 6; k++) begin
            run(ops[k], MINN, MAXP);
            run(ops[k], MAXP, MINN);
            run(ops[k], MAXP, MAXP);
            run(ops[k], MINN, MINN);
            run(ops[k], '0, '0);
            run(ops[k], ONES, ONE);
            run(ops[k], MINN, ONE);
            run(ops[k], MAXP, ONE);
            run(ops[k], '0, ONES);
        end
        // R7 overflowing compares, R6 boundary sums
        run(4'b0111, MINN, ONE);
        run(4'b0111, MAXP, ONES);
        run(4'b0010, MAXP, ONE);
        run(4'b0110, MINN, ONE);
        for (int n = 0; n < 1500; n++) begin
            logic [W-1:0] x, y;
            x = $urandom();
            y = (n % 7 == 0) ? x : $urandom();
            run(ops[$urandom_range(5, 0)], x, y);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule